// File: doc/BRIEF.md
# Half-Bit Duration Track Decoder

This block recovers a bit stream from a bipolar track command waveform. The waveform reaches it as one asynchronous polarity signal. Information is carried only by the time between polarity transitions. Each bit has two parts, a first half and a last half. A short half of about 58 µs marks a one, and a long half of 100 µs or more marks a zero. There is no clock and no framing marker, so the decoder has to work out for itself which transitions end a bit and which fall in the middle of one.

The input is first synchronised to the local clock. Pulses shorter than a programmable glitch time are filtered out. The time between filtered transitions is then measured in whole microseconds. Each measured half is put into one of three classes: a one half, a zero half, or invalid, using receive windows that are wider than the transmit windows. Halves are then paired into bits. Two equal-class halves give a bit, and a one bit also needs its two halves to agree within a small delta. When a pair mixes a one half with a zero half, the older half is dropped. This shifts the bit phase by one transition, which is how the decoder finds bit alignment after start-up or after noise. Packet assembly, address matching and checksum checking happen downstream.

Top module: `trk_halfbit_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `bit_stb_o` and `err_stb_o` are 0.
- R2: A pulse on `trk_in` that lasts fewer than GLITCH_US × CLKS_PER_US clocks has no effect. The half-bit it falls inside is measured as if the pulse were absent.
- R3: The first filtered transition after reset only starts interval timing. It produces no bit and no error.
- R4: A half-bit that measures from ONE_MIN_US (52) to ONE_MAX_US (64) µs, both ends included, is a one half.
- R5: A half-bit that measures from ZERO_MIN_US (90) to ZERO_MAX_US (10000) µs, both ends included, is a zero half. Two consecutive zero halves give a bit of value 0 on `bit_val_o`.
- R6: Two consecutive one halves give a bit of value 1 when their durations differ by at most ONE_DELTA_US (6) µs. If they differ by more, the pair gives one error strobe and no bit, and pairing restarts.
- R7: A half-bit outside both windows (below 52 µs, from 65 to 89 µs, or above 10000 µs) gives exactly one error strobe, and the next half starts a new bit. A bit strobe and an error strobe are never high in the same cycle.
- R8: When a stored half is followed by a half of the other valid class, the stored half is discarded without an error, and the new half becomes the first half of a bit.
- R9: `bit_stb_o` is one clock wide. It rises no later than FILT_CLKS + 8 clocks after the `trk_in` transition that ends the second half.
- R10: If no transition arrives for more than ZERO_MAX_US µs, one error strobe is given at the moment the limit is exceeded. The transition that finally ends that interval produces neither a bit nor a second error. The interval counter never exceeds ZERO_MAX_US + 1.
- R11: An interval of N clocks counts as floor(N / CLKS_PER_US) µs, so a half of 64 µs plus a fraction still counts as a one half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock, CLKS_PER_US cycles per microsecond |
| rst | input | 1 | Synchronous active-high reset |
| trk_in | input | 1 | Asynchronous track polarity sample |
| bit_stb_o | output | 1 | One-cycle strobe: a bit was decoded |
| bit_val_o | output | 1 | Value of the decoded bit, valid with `bit_stb_o` |
| err_stb_o | output | 1 | One-cycle strobe: invalid half, mismatched one pair, or over-long interval |

## Verification
Two functions can fall in the same clock cycle: the over-long-interval timeout and the capture of a half on a transition. A half of exactly 10001 µs ends on the very clock in which the microsecond counter would reach its saturation value. The bench provokes this by driving a 10001 µs half, and it judges the result by requiring exactly one error strobe and no bit. A 10002 µs half is run next to it as the pure timeout case, where the closing transition must stay silent. The sweeps across the one window, the zero window and the one-pair delta are checked against arithmetic on the microsecond values the bench drives.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic [1:0] {
    HB_NONE = 2'd0,
    HB_ONE  = 2'd1,
    HB_ZERO = 2'd2,
    HB_BAD  = 2'd3
  } hb_kind_t;
endpackage

// File: rtl/trk_sync_filter.sv
// Two-flop synchroniser followed by a hold-time glitch filter.
// The filtered level follows the synchronised input only after the input
// has differed from it for FILT_CLKS consecutive clocks.
module trk_sync_filter #(
  parameter int FILT_CLKS = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic sync_o,
  output logic lvl_o,
  output logic edge_o
);
  localparam int FW = $clog2(FILT_CLKS + 1);

  logic          s1_q, s2_q;
  logic [FW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      lvl_o  <= 1'b0;
      hold_q <= '0;
      edge_o <= 1'b0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      edge_o <= 1'b0;
      if (s2_q == lvl_o) begin
        hold_q <= '0;
      end else if (hold_q == FW'(FILT_CLKS - 1)) begin
        lvl_o  <= s2_q;
        hold_q <= '0;
        edge_o <= 1'b1;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end
  end

  assign sync_o = s2_q;
endmodule

// File: rtl/trk_interval_meter.sv
// Measures whole microseconds between filtered transitions.
// The counter saturates at SAT_US; reaching it raises a single timeout and
// marks the running interval stale so its closing transition is ignored.
module trk_interval_meter #(
  parameter int CLKS_PER_US = 125,
  parameter int SAT_US      = 10001,
  parameter int DUR_W       = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  output logic [DUR_W-1:0] dur_o,
  output logic             half_vld_o,
  output logic             tmo_o,
  output logic [DUR_W-1:0] us_cnt_o
);
  localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

  logic [PW-1:0]    pre_q;
  logic [DUR_W-1:0] cnt_q;
  logic             armed_q;
  logic             stale_q;
  logic             tick;
  logic [DUR_W-1:0] cnt_next;

  always_comb begin
    tick     = (pre_q == PW'(CLKS_PER_US - 1));
    cnt_next = cnt_q;
    if (tick && (cnt_q != DUR_W'(SAT_US)))
      cnt_next = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q      <= '0;
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      stale_q    <= 1'b0;
      dur_o      <= '0;
      half_vld_o <= 1'b0;
      tmo_o      <= 1'b0;
    end else begin
      half_vld_o <= 1'b0;
      tmo_o      <= 1'b0;
      if (edge_i) begin
        pre_q   <= '0;
        cnt_q   <= '0;
        armed_q <= 1'b1;
        stale_q <= 1'b0;
        if (armed_q && !stale_q) begin
          dur_o      <= cnt_next;
          half_vld_o <= 1'b1;
        end
      end else begin
        pre_q <= tick ? '0 : pre_q + 1'b1;
        cnt_q <= cnt_next;
        if (armed_q && !stale_q && tick && (cnt_q == DUR_W'(SAT_US - 1))) begin
          tmo_o   <= 1'b1;
          stale_q <= 1'b1;
        end
      end
    end
  end

  assign us_cnt_o = cnt_q;
endmodule

// File: rtl/trk_halfbit_classify.sv
// Sorts a measured half-bit into the receive windows.
module trk_halfbit_classify
  import trk_pkg::*;
#(
  parameter int DUR_W       = 14,
  parameter int ONE_MIN_US  = 52,
  parameter int ONE_MAX_US  = 64,
  parameter int ZERO_MIN_US = 90,
  parameter int ZERO_MAX_US = 10000
) (
  input  logic [DUR_W-1:0] dur_i,
  output hb_kind_t         kind_o
);
  always_comb begin
    if ((dur_i >= DUR_W'(ONE_MIN_US)) && (dur_i <= DUR_W'(ONE_MAX_US)))
      kind_o = HB_ONE;
    else if ((dur_i >= DUR_W'(ZERO_MIN_US)) && (dur_i <= DUR_W'(ZERO_MAX_US)))
      kind_o = HB_ZERO;
    else
      kind_o = HB_BAD;
  end
endmodule

// File: rtl/trk_bit_pairer.sv
// Pairs classified halves into bits and realigns the bit phase.
module trk_bit_pairer
  import trk_pkg::*;
#(
  parameter int DUR_W        = 14,
  parameter int ONE_DELTA_US = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_vld_i,
  input  hb_kind_t         kind_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             tmo_i,
  output logic             bit_stb_o,
  output logic             bit_val_o,
  output logic             err_stb_o
);
  logic             have_q;
  hb_kind_t         first_kind_q;
  logic [DUR_W-1:0] first_dur_q;
  logic [DUR_W-1:0] gap;

  always_comb begin
    gap = (first_dur_q >= dur_i) ? (first_dur_q - dur_i) : (dur_i - first_dur_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q       <= 1'b0;
      first_kind_q <= HB_NONE;
      first_dur_q  <= '0;
      bit_stb_o    <= 1'b0;
      bit_val_o    <= 1'b0;
      err_stb_o    <= 1'b0;
    end else begin
      bit_stb_o <= 1'b0;
      err_stb_o <= 1'b0;
      if (tmo_i) begin
        err_stb_o <= 1'b1;
        have_q    <= 1'b0;
      end else if (half_vld_i) begin
        if (kind_i == HB_BAD || kind_i == HB_NONE) begin
          err_stb_o <= 1'b1;
          have_q    <= 1'b0;
        end else if (!have_q || (kind_i != first_kind_q)) begin
          have_q       <= 1'b1;
          first_kind_q <= kind_i;
          first_dur_q  <= dur_i;
        end else if (kind_i == HB_ZERO) begin
          bit_stb_o <= 1'b1;
          bit_val_o <= 1'b0;
          have_q    <= 1'b0;
        end else begin
          have_q <= 1'b0;
          if (gap <= DUR_W'(ONE_DELTA_US)) begin
            bit_stb_o <= 1'b1;
            bit_val_o <= 1'b1;
          end else begin
            err_stb_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/trk_halfbit_decoder.sv
module trk_halfbit_decoder
  import trk_pkg::*;
#(
  parameter int CLKS_PER_US  = 125,
  parameter int GLITCH_US    = 2,
  parameter int ONE_MIN_US   = 52,
  parameter int ONE_MAX_US   = 64,
  parameter int ZERO_MIN_US  = 90,
  parameter int ZERO_MAX_US  = 10000,
  parameter int ONE_DELTA_US = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic trk_in,
  output logic bit_stb_o,
  output logic bit_val_o,
  output logic err_stb_o
);
  localparam int FILT_CLKS = GLITCH_US * CLKS_PER_US;
  localparam int SAT_US    = ZERO_MAX_US + 1;
  localparam int DUR_W     = $clog2(SAT_US + 1);

  logic             sync_lvl;
  logic             filt_lvl;
  logic             filt_edge;
  logic [DUR_W-1:0] half_dur;
  logic             half_vld;
  logic             tmo;
  logic [DUR_W-1:0] us_cnt;
  hb_kind_t         half_kind;

  trk_sync_filter #(.FILT_CLKS(FILT_CLKS)) u_filt (
    .clk    (clk),
    .rst    (rst),
    .din    (trk_in),
    .sync_o (sync_lvl),
    .lvl_o  (filt_lvl),
    .edge_o (filt_edge)
  );

  trk_interval_meter #(
    .CLKS_PER_US (CLKS_PER_US),
    .SAT_US      (SAT_US),
    .DUR_W       (DUR_W)
  ) u_meter (
    .clk        (clk),
    .rst        (rst),
    .edge_i     (filt_edge),
    .dur_o      (half_dur),
    .half_vld_o (half_vld),
    .tmo_o      (tmo),
    .us_cnt_o   (us_cnt)
  );

  trk_halfbit_classify #(
    .DUR_W       (DUR_W),
    .ONE_MIN_US  (ONE_MIN_US),
    .ONE_MAX_US  (ONE_MAX_US),
    .ZERO_MIN_US (ZERO_MIN_US),
    .ZERO_MAX_US (ZERO_MAX_US)
  ) u_class (
    .dur_i  (half_dur),
    .kind_o (half_kind)
  );

  trk_bit_pairer #(
    .DUR_W        (DUR_W),
    .ONE_DELTA_US (ONE_DELTA_US)
  ) u_pair (
    .clk        (clk),
    .rst        (rst),
    .half_vld_i (half_vld),
    .kind_i     (half_kind),
    .dur_i      (half_dur),
    .tmo_i      (tmo),
    .bit_stb_o  (bit_stb_o),
    .bit_val_o  (bit_val_o),
    .err_stb_o  (err_stb_o)
  );
endmodule

// File: rtl/trk_decoder_chk.sv
module trk_decoder_chk #(
  parameter int SAT_US = 10001,
  parameter int DUR_W  = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_stb,
  input logic             err_stb,
  input logic             half_vld,
  input logic             tmo,
  input logic [DUR_W-1:0] us_cnt,
  input logic             sync_lvl,
  input logic             filt_lvl
);
  // R9: bit strobe lasts one clock
  p_bit_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);

  // R9: a bit is only issued right after a measured half
  p_bit_after_half_r9: assert property (@(posedge clk) disable iff (rst)
    bit_stb |-> $past(half_vld));

  // R7: an error needs a measured half or a timeout one cycle earlier
  p_err_source_r7: assert property (@(posedge clk) disable iff (rst)
    err_stb |-> $past(half_vld || tmo));

  // R7: bit and error strobes are exclusive
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(bit_stb && err_stb));

  // R10: microsecond counter never passes its saturation value
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    us_cnt <= DUR_W'(SAT_US));

  // R10: a timeout is never followed by a capture in the next cycle
  p_tmo_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    tmo |=> !half_vld);

  // R2: filtered level moves only toward the synchronised level
  p_filt_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(filt_lvl) |-> $past(sync_lvl));
  p_filt_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(filt_lvl) |-> !$past(sync_lvl));
endmodule

bind trk_halfbit_decoder trk_decoder_chk #(
  .SAT_US (SAT_US),
  .DUR_W  (DUR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_stb  (bit_stb_o),
  .err_stb  (err_stb_o),
  .half_vld (half_vld),
  .tmo      (tmo),
  .us_cnt   (us_cnt),
  .sync_lvl (sync_lvl),
  .filt_lvl (filt_lvl)
);

// File: tb/tb_trk_halfbit_decoder.sv
`timescale 1ns/1ps
module tb_trk_halfbit_decoder;
  localparam int C    = 4;   // clocks per microsecond in this bench
  localparam int GUS  = 2;
  localparam int FILT = GUS * C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trk_in = 1'b0;
  logic bit_stb, bit_val, err_stb;

  always #4 clk = ~clk;   // 125 MHz

  trk_halfbit_decoder #(.CLKS_PER_US(C), .GLITCH_US(GUS)) dut (
    .clk       (clk),
    .rst       (rst),
    .trk_in    (trk_in),
    .bit_stb_o (bit_stb),
    .bit_val_o (bit_val),
    .err_stb_o (err_stb)
  );

  int total = 0, bad = 0;
  int n_bits = 0, n_ones = 0, n_errs = 0;
  int e_bits = 0, e_ones = 0, e_errs = 0;
  int cyc = 0, last_tog = 0, last_bit = 0;
  bit pend = 1'b0;
  string pend_tag;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (bit_stb) begin
        n_bits   <= n_bits + 1;
        n_ones   <= n_ones + (bit_val ? 1 : 0);
        last_bit <= cyc;
      end
      if (err_stb) n_errs <= n_errs + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_pend();
    if (pend) begin
      chk(n_bits == e_bits, {pend_tag, " bits"}, n_bits, e_bits);
      chk(n_ones == e_ones, {pend_tag, " ones"}, n_ones, e_ones);
      chk(n_errs == e_errs, {pend_tag, " errs"}, n_errs, e_errs);
      pend = 1'b0;
    end
  endtask

  // one half of clks clocks, ended by a transition; pending checks run early in it
  task automatic half(input int clks);
    repeat (20) @(negedge clk);
    run_pend();
    repeat (clks - 20) @(negedge clk);
    trk_in   = ~trk_in;
    last_tog = cyc;
  endtask

  function automatic int kind(input int clks);   // 1 one, 2 zero, 3 bad
    int us = clks / C;
    if (us >= 52 && us <= 64) return 1;
    if (us >= 90 && us <= 10000) return 2;
    return 3;
  endfunction

  task automatic expect_set(input string tag);
    pend_tag = tag;
    pend     = 1'b1;
  endtask

  // pair of halves of the same class (or both bad); pairing clear before and after
  task automatic pair(input int a, input int b, input string tag);
    int ka = kind(a);
    int kb = kind(b);
    int da = (a / C > b / C) ? a / C - b / C : b / C - a / C;
    half(a);
    half(b);
    if (ka == 3) e_errs++;
    if (kb == 3) e_errs++;
    if (ka == 2 && kb == 2) e_bits++;
    if (ka == 1 && kb == 1) begin
      if (da <= 6) begin e_bits++; e_ones++; end
      else e_errs++;
    end
    expect_set(tag);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(bit_stb == 1'b0 && err_stb == 1'b0, "R1 strobes in reset", bit_stb + err_stb, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bit_stb == 1'b0 && err_stb == 1'b0, "R1 strobes after reset", bit_stb + err_stb, 0);

    // R3: arming transition after a 20 us idle gives nothing
    repeat (20 * C) @(negedge clk);
    trk_in = 1'b1;
    expect_set("R3 arming edge");

    // R4: sweep of equal one halves across the window
    for (int us = 48; us <= 68; us++) pair(us * C, us * C, "R4 one window");

    // R6: delta sweep from a 52 us first half
    for (int d = 0; d <= 12; d++) pair(52 * C, (52 + d) * C, "R6 one delta");

    // R5: zero window lower edge
    for (int us = 86; us <= 94; us++) pair(us * C, us * C, "R5 zero window");

    // R11: fractional microseconds truncate
    pair(64 * C + C - 1, 64 * C + C - 1, "R11 64us plus fraction");
    pair(51 * C + C - 1, 51 * C + C - 1, "R11 51us plus fraction");

    // R8: mixed classes realign
    half(58 * C); half(100 * C); half(100 * C);
    e_bits++;
    expect_set("R8 one then zero pair");
    half(100 * C); half(58 * C); half(58 * C);
    e_bits++; e_ones++;
    expect_set("R8 zero then one pair");

    // R9: latency of the last bit strobe
    repeat (FILT + 12) @(negedge clk);
    chk(last_bit > last_tog && last_bit - last_tog <= FILT + 8, "R9 bit latency",
        last_bit - last_tog, FILT + 8);
    half(58 * C - FILT - 12); half(58 * C);
    e_bits++; e_ones++;
    expect_set("R9 one bit after latency check");

    // R2: sub-filter pulse inside a zero half
    repeat (200) @(negedge clk);
    run_pend();
    trk_in = ~trk_in;
    repeat (FILT - 1) @(negedge clk);
    trk_in = ~trk_in;
    repeat (200 - FILT + 1) @(negedge clk);
    trk_in = ~trk_in;
    half(100 * C);
    e_bits++;
    expect_set("R2 glitch ignored");

    // R5: upper edge of the zero window
    pair(10000 * C, 100 * C, "R5 10000us zero half");

    // R10: transition coincides with saturation, then pure timeout
    half(10001 * C);
    e_errs++;
    expect_set("R10 10001us half coincident");
    half(10002 * C);
    e_errs++;
    expect_set("R10 10002us timeout once");
    pair(58 * C, 58 * C, "R10 recovery after timeout");

    repeat (FILT + 20) @(negedge clk);
    run_pend();
    done = 1'b1;
  end

  initial begin
    repeat (198000) @(negedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
  end

  initial begin
    wait (done);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 198000);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule